// File: doc/BRIEF.md
# Return Address Shadow Guard

This block holds a protected second copy of every return address a program pushes. Each call event stores its return address in an internal stack that ordinary code cannot reach. Each return event presents the address that was just popped from the normal, software-visible stack. The block compares that address with the newest protected entry and raises a control-flow fault when they differ. The guard therefore catches a return address that was overwritten in normal memory.

The position of the protected stack is held in a pointer register. Only supervisor code may read or load this pointer, for example to save and restore it on a context switch. A user-mode attempt to touch the pointer raises a privilege trap and leaves the pointer unchanged. All faults and traps are registered single-cycle pulses. The pointer read-back is combinational.

Top module: `retaddr_guard`

## Requirements
- R1: After reset the pointer is 0 and `cfi_fault`, `ovf_fault` and `priv_trap` are low.
- R2: A call alone with pointer below DEPTH stores `call_addr` at the pointer index and raises the pointer by one on the next edge, with no fault.
- R3: A return alone with pointer above 0 compares `ret_addr` with the entry at pointer minus one and lowers the pointer by one. On a match no fault is raised.
- R4: When that comparison differs, `cfi_fault` is high for the cycle after the return edge, and the pointer still lowers by one.
- R5: A return alone with pointer 0 raises `cfi_fault` and leaves the pointer at 0.
- R6: A call alone with pointer equal to DEPTH raises `ovf_fault`, stores nothing and leaves the pointer unchanged.
- R7: A call and a return in the same cycle raise `cfi_fault` and change neither the pointer nor the stored entries.
- R8: `ptr_wr` with `priv_sup`=1 loads the pointer from `ptr_wdata` at the next edge, saturating values above DEPTH to DEPTH. Call and return events in that cycle are ignored and raise no fault.
- R9: `ptr_rdata` equals the current pointer in the same cycle when `ptr_rd` and `priv_sup` are both 1, and is 0 otherwise.
- R10: `ptr_rd` or `ptr_wr` with `priv_sup`=0 raises `priv_trap` for the cycle after the edge and does not change the pointer. `ptr_rdata` reads 0.
- R11: Each fault or trap output is a one-cycle pulse and is low after any cycle that has no call, return, read or write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_vld | input | 1 | Call event this cycle |
| call_addr | input | ADDR_W | Return address saved by the call |
| ret_vld | input | 1 | Return event this cycle |
| ret_addr | input | ADDR_W | Address popped from the normal stack |
| ptr_rd | input | 1 | Request to read the shadow pointer |
| ptr_wr | input | 1 | Request to load the shadow pointer |
| ptr_wdata | input | PTR_W | Value to load into the pointer |
| priv_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| ptr_rdata | output | PTR_W | Pointer read-back |
| cfi_fault | output | 1 | Control-flow violation pulse |
| ovf_fault | output | 1 | Shadow stack overflow pulse |
| priv_trap | output | 1 | Privilege trap pulse |

## Verification
The three fault pulses come from a register, so each one is due in the cycle that follows the clock edge on which its request was sampled. The bench drives a request on the falling edge and checks the pulses just after the next rising edge. `ptr_rdata` is combinational, so the bench checks it one nanosecond after driving and before the edge that could move the pointer. A pointer change is seen only through a supervisor read in a later step. The bench fills the stack to its limit, loads every pointer value, and compares each result with a model it keeps.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SETPTR,
    OP_CLASH,
    OP_OVF,
    OP_UNDER
  } rg_op_e;

  // saturate a requested pointer value to the stack capacity
  function automatic int sat_ptr(int v, int depth);
    return (v > depth) ? depth : v;
  endfunction

endpackage

// File: rtl/rg_decode.sv
module rg_decode
  import rg_pkg::*;
(
  input  logic   call_vld,
  input  logic   ret_vld,
  input  logic   ptr_rd,
  input  logic   ptr_wr,
  input  logic   priv_sup,
  input  logic   ptr_full,
  input  logic   ptr_empty,
  input  logic   top_match,
  output rg_op_e op,
  output logic   cfi_evt,
  output logic   ovf_evt,
  output logic   priv_viol
);

  always_comb begin
    if (priv_sup && ptr_wr)         op = OP_SETPTR;
    else if (call_vld && ret_vld)   op = OP_CLASH;
    else if (call_vld)              op = ptr_full  ? OP_OVF   : OP_PUSH;
    else if (ret_vld)               op = ptr_empty ? OP_UNDER : OP_POP;
    else                            op = OP_IDLE;
  end

  assign cfi_evt   = (op == OP_CLASH) || (op == OP_UNDER) ||
                     ((op == OP_POP) && !top_match);
  assign ovf_evt   = (op == OP_OVF);
  assign priv_viol = !priv_sup && (ptr_rd || ptr_wr);

endmodule

// File: rtl/rg_store.sv
module rg_store #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);

  logic [DEPTH-1:0][ADDR_W-1:0] sel_val;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))     q <= wr_data;
    end
    assign sel_val[i] = (rd_idx == IDX_W'(i)) ? q : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) rd_data = rd_data | sel_val[i];
  end

endmodule

// File: rtl/rg_ptr.sv
module rg_ptr
  import rg_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rg_op_e           op,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else begin
      case (op)
        OP_PUSH:   ptr_q <= ptr_q + PTR_W'(1);
        OP_POP:    ptr_q <= ptr_q - PTR_W'(1);
        OP_SETPTR: ptr_q <= load_val;
        default:   ptr_q <= ptr_q;
      endcase
    end
  end

endmodule

// File: rtl/retaddr_guard.sv
module retaddr_guard
  import rg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_vld,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic              ret_vld,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              ptr_rd,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              priv_sup,
  output logic [PTR_W-1:0]  ptr_rdata,
  output logic              cfi_fault,
  output logic              ovf_fault,
  output logic              priv_trap
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] FULL_PTR = PTR_W'(DEPTH);

  // named internal events
  rg_op_e            op;
  logic              cfi_evt, ovf_evt, priv_viol;
  logic [PTR_W-1:0]  ptr_q;
  logic              ptr_full, ptr_empty, top_match;
  logic [ADDR_W-1:0] top_entry;
  logic [IDX_W-1:0]  top_idx;
  logic [PTR_W-1:0]  load_val;

  assign ptr_full  = (ptr_q == FULL_PTR);
  assign ptr_empty = (ptr_q == '0);
  assign top_idx   = ptr_empty ? '0 : IDX_W'(ptr_q - PTR_W'(1));
  assign top_match = (top_entry == ret_addr);
  assign load_val  = PTR_W'(sat_ptr(int'(ptr_wdata), DEPTH));

  rg_decode u_decode (
    .call_vld (call_vld),
    .ret_vld  (ret_vld),
    .ptr_rd   (ptr_rd),
    .ptr_wr   (ptr_wr),
    .priv_sup (priv_sup),
    .ptr_full (ptr_full),
    .ptr_empty(ptr_empty),
    .top_match(top_match),
    .op       (op),
    .cfi_evt  (cfi_evt),
    .ovf_evt  (ovf_evt),
    .priv_viol(priv_viol)
  );

  rg_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (op == OP_PUSH),
    .wr_idx (IDX_W'(ptr_q)),
    .wr_data(call_addr),
    .rd_idx (top_idx),
    .rd_data(top_entry)
  );

  rg_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .load_val(load_val),
    .ptr_q   (ptr_q)
  );

  assign ptr_rdata = (ptr_rd && priv_sup) ? ptr_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfi_fault <= 1'b0;
      ovf_fault <= 1'b0;
      priv_trap <= 1'b0;
    end else begin
      cfi_fault <= cfi_evt;
      ovf_fault <= ovf_evt;
      priv_trap <= priv_viol;
    end
  end

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_vld,
  input logic             ret_vld,
  input logic             ptr_rd,
  input logic             ptr_wr,
  input logic [PTR_W-1:0] ptr_wdata,
  input logic             priv_sup,
  input logic [PTR_W-1:0] ptr_q,
  input logic [PTR_W-1:0] ptr_rdata,
  input logic             cfi_fault,
  input logic             ovf_fault,
  input logic             priv_trap
);

  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);
  logic sup_wr;
  assign sup_wr = priv_sup && ptr_wr;

  p_ptr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CAP);

  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_wr && call_vld && !ret_vld && ptr_q < CAP)
    |=> (ptr_q == $past(ptr_q) + PTR_W'(1)) && !ovf_fault);

  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_wr && ret_vld && !call_vld && ptr_q != '0)
    |=> ptr_q == $past(ptr_q) - PTR_W'(1));

  p_empty_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_wr && ret_vld && !call_vld && ptr_q == '0)
    |=> cfi_fault && ptr_q == '0);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_wr && call_vld && !ret_vld && ptr_q == CAP)
    |=> ovf_fault && $stable(ptr_q));

  p_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_wr && call_vld && ret_vld) |=> cfi_fault && $stable(ptr_q));

  p_setptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_wr |=> (ptr_q == (($past(ptr_wdata) > CAP) ? CAP : $past(ptr_wdata)))
               && !cfi_fault && !ovf_fault);

  p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rd && priv_sup) |-> ptr_rdata == ptr_q);

  p_user_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_sup && (ptr_rd || ptr_wr)) |=> priv_trap);

  p_user_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_sup && ptr_wr && !call_vld && !ret_vld) |=> $stable(ptr_q));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_vld && !ret_vld && !ptr_rd && !ptr_wr)
    |=> !cfi_fault && !ovf_fault && !priv_trap);

endmodule

bind retaddr_guard rg_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .call_vld (call_vld),
  .ret_vld  (ret_vld),
  .ptr_rd   (ptr_rd),
  .ptr_wr   (ptr_wr),
  .ptr_wdata(ptr_wdata),
  .priv_sup (priv_sup),
  .ptr_q    (ptr_q),
  .ptr_rdata(ptr_rdata),
  .cfi_fault(cfi_fault),
  .ovf_fault(ovf_fault),
  .priv_trap(priv_trap)
);

// File: tb/retaddr_guard_bench.sv
module retaddr_guard_bench;

  localparam int ADDR_W = 16;
  localparam int DEPTH  = 8;
  localparam int PTR_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              call_vld = 1'b0, ret_vld = 1'b0;
  logic [ADDR_W-1:0] call_addr = '0, ret_addr = '0;
  logic              ptr_rd = 1'b0, ptr_wr = 1'b0, priv_sup = 1'b0;
  logic [PTR_W-1:0]  ptr_wdata = '0;
  logic [PTR_W-1:0]  ptr_rdata;
  logic              cfi_fault, ovf_fault, priv_trap;

  always #2 clk = ~clk;

  retaddr_guard #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_retaddr_guard (
    .clk(clk), .rst_n(rst_n),
    .call_vld(call_vld), .call_addr(call_addr),
    .ret_vld(ret_vld), .ret_addr(ret_addr),
    .ptr_rd(ptr_rd), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .priv_sup(priv_sup), .ptr_rdata(ptr_rdata),
    .cfi_fault(cfi_fault), .ovf_fault(ovf_fault), .priv_trap(priv_trap)
  );

  int tests = 0, fails = 0;
  int mptr = 0;
  logic [ADDR_W-1:0] mstk [DEPTH];

  function automatic logic [ADDR_W-1:0] ra(int i);
    return ADDR_W'(32'h4000 + i * 32'h0137 + (i << 9));
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one request cycle: drive at falling edge, check read-back before the
  // rising edge, check registered pulses just after it
  task automatic step(string tag, bit c, logic [ADDR_W-1:0] ca, bit r,
                      logic [ADDR_W-1:0] ar, bit rd, bit wr, int wd, bit sup);
    bit ecfi = 0, eovf = 0, etrap = 0;
    int erd;
    @(negedge clk);
    call_vld = c; call_addr = ca; ret_vld = r; ret_addr = ar;
    ptr_rd = rd; ptr_wr = wr; ptr_wdata = PTR_W'(wd); priv_sup = sup;
    erd = (rd && sup) ? mptr : 0;
    if (!sup && (rd || wr)) etrap = 1;
    if (sup && wr) mptr = (wd > DEPTH) ? DEPTH : wd;
    else if (c && r) ecfi = 1;
    else if (c) begin
      if (mptr == DEPTH) eovf = 1;
      else begin mstk[mptr] = ca; mptr++; end
    end else if (r) begin
      if (mptr == 0) ecfi = 1;
      else begin
        if (mstk[mptr-1] != ar) ecfi = 1;
        mptr--;
      end
    end
    #1;
    chk({tag, " rdata R9"}, int'(ptr_rdata), erd);
    @(posedge clk); #1;
    chk({tag, " cfi_fault"}, int'(cfi_fault), int'(ecfi));
    chk({tag, " ovf_fault"}, int'(ovf_fault), int'(eovf));
    chk({tag, " priv_trap"}, int'(priv_trap), int'(etrap));
  endtask

  task automatic idle(string tag);
    step(tag, 0, '0, 0, '0, 0, 0, 0, 1);
  endtask

  task automatic rdptr(string tag);
    step(tag, 0, '0, 0, '0, 1, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset cfi R1", int'(cfi_fault), 0);
    chk("reset ovf R1", int'(ovf_fault), 0);
    chk("reset trap R1", int'(priv_trap), 0);
    @(negedge clk); rst_n = 1'b1;
    rdptr("reset ptr R1");

    // R2: fill, reading the pointer alongside each call
    for (int i = 0; i < DEPTH; i++) step("push R2", 1, ra(i), 0, '0, 1, 0, 0, 1);
    rdptr("full R2");
    // R6: overflow leaves pointer and contents
    step("overflow R6", 1, 16'hDEAD, 0, '0, 0, 0, 0, 1);
    idle("pulse end R11");
    step("overflow again R6", 1, 16'hBEEF, 0, '0, 1, 0, 0, 1);
    // R3: matching pops in reverse
    for (int i = DEPTH - 1; i >= 0; i--) step("pop R3", 0, '0, 1, ra(i), 1, 0, 0, 1);
    rdptr("empty R3");
    // R5: empty return
    step("empty ret R5", 0, '0, 1, 16'h1234, 0, 0, 0, 1);
    rdptr("empty kept R5");

    // R4: mismatch still pops
    for (int i = 0; i < 3; i++) step("push R2", 1, ra(i + 20), 0, '0, 0, 0, 0, 1);
    step("mismatch R4", 0, '0, 1, ra(22) ^ 16'h0001, 0, 0, 0, 1);
    idle("pulse end R11");
    rdptr("after mismatch R4");
    step("pop R3", 0, '0, 1, ra(21), 0, 0, 0, 1);
    step("mismatch R4", 0, '0, 1, ra(99), 0, 0, 0, 1);

    // R7: call and return together
    step("push R2", 1, ra(30), 0, '0, 0, 0, 0, 1);
    step("clash R7", 1, ra(31), 1, ra(30), 1, 0, 0, 1);
    rdptr("after clash R7");
    step("pop R3", 0, '0, 1, ra(30), 0, 0, 0, 1);

    // R8: every load value, read back next cycle
    for (int v = 0; v < (1 << PTR_W); v++) begin
      step("load R8", 0, '0, 0, '0, 0, 1, v, 1);
      rdptr("load readback R8");
    end
    step("load beats call R8", 1, ra(40), 0, '0, 0, 1, 2, 1);
    step("load beats ret R8", 0, '0, 1, ra(40), 0, 1, 1, 1);
    rdptr("after load R8");

    // R10: user-mode access traps, pointer kept
    for (int v = 0; v < 4; v++) begin
      step("user write R10", 0, '0, 0, '0, 0, 1, v + 5, 0);
      step("user read R10", 0, '0, 0, '0, 1, 0, 0, 0);
      step("user both R10", 0, '0, 0, '0, 1, 1, v, 0);
      rdptr("user kept R10");
    end
    idle("pulse end R11");

    // context restore keeps contents (R8 with R3)
    step("load R8", 0, '0, 0, '0, 0, 1, 0, 1);
    step("push R2", 1, ra(50), 0, '0, 0, 0, 0, 1);
    step("push R2", 1, ra(51), 0, '0, 0, 0, 0, 1);
    step("switch out R8", 0, '0, 0, '0, 0, 1, 6, 1);
    step("switch in R8", 0, '0, 0, '0, 0, 1, 2, 1);
    step("pop restored R3", 0, '0, 1, ra(51), 0, 0, 0, 1);
    step("pop restored R3", 0, '0, 1, ra(50), 0, 0, 0, 1);
    idle("final R11");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule